// File: doc/BRIEF.md
# Command-Driven Pulse Count Reporter

This block counts rising edges seen on an asynchronous pulse input and reports the running total to a host. The host's commands arrive as bytes from an external UART receiver, each presented with a one-cycle valid strobe. One command zeroes the live counter. Another command freezes a copy of the count and starts a report.

A report is a string of ASCII hexadecimal digits, most significant nibble first, ending with carriage return and line feed. The report goes out one byte at a time through an external UART transmitter. Each byte is offered with a single-cycle send strobe, and the block waits for the transmitter's busy flag to drop before offering the next byte.

The pulse input is resynchronised to the system clock. Counting continues while a report is in flight, so the host can poll without stopping acquisition.

Top module: `pulse_count_reporter`

## Requirements
- R1: After reset the live count is zero, no report is in progress and `txSend` is low.
- R2: The input passes through two synchronising flops. Each low-to-high transition of `pulseIn` adds one to the live count, provided every high and low level lasts at least two clock cycles.
- R3: A valid command byte of 0x61 sets the live count to zero.
- R4: When no report is in progress, a valid command byte of 0x62 copies the live count into a snapshot and starts a report of that snapshot.
- R5: A report is COUNT_W/4 hex characters, most significant nibble first, followed by 0x0D and then 0x0A.
- R6: Nibble values 0 to 9 become bytes 0x30 to 0x39. Values 10 to 15 become uppercase letters, bytes 0x41 to 0x46.
- R7: `txSend` is high for exactly one cycle per byte, and `txByte` carries that byte in the same cycle.
- R8: The transmitter raises `txBusy` no later than the cycle after `txSend`. No new byte is offered until `txBusy` has been seen low.
- R9: Pulses keep counting during a report. A 0x61 received during a report clears the live count and leaves the snapshot being sent unchanged.
- R10: A 0x62 received while a report is in progress is ignored and produces no further report.
- R11: Any command byte other than 0x61 and 0x62 is ignored. It changes neither the count nor the output.
- R12: The live count wraps to zero after 2^COUNT_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous pulse input to count |
| rxByte | input | 8 | Received command byte |
| rxValid | input | 1 | One-cycle strobe marking rxByte valid |
| txByte | output | 8 | Byte offered to the transmitter |
| txSend | output | 1 | One-cycle strobe to send txByte |
| txBusy | input | 1 | Transmitter busy flag |

## Verification
The count path is exercised in several ways:
- Random bursts of pulses are accumulated across several reports, so each report shows the running total.
- A directed count that fills every nibble with a letter value separates the digit and letter ranges of the hex mapping.
- A count pushed just past full scale tells a wrapping counter apart from a saturating one.

The command path is exercised as follows:
- Pulses, a clear command and a second snapshot command are injected while a report is being sent. The result separates the frozen snapshot from the live counter and shows that the extra request is dropped.
- Junk command bytes check that they produce neither a report nor a change in the next value.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic [1:0] {
    SEL_HEX = 2'd0,
    SEL_CR  = 2'd1,
    SEL_LF  = 2'd2
  } charSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     clrCount;
    logic     takeSnap;
    logic     shiftNib;
    charSel_t charSel;
  } ctrlStrobes_t;

  localparam logic [7:0] CMD_CLEAR = 8'h61;
  localparam logic [7:0] CMD_SNAP  = 8'h62;
  localparam logic [7:0] CHAR_CR   = 8'h0D;
  localparam logic [7:0] CHAR_LF   = 8'h0A;

  function automatic logic [7:0] nibToAscii(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'd0, nib};
    else             return 8'h37 + {4'd0, nib};
  endfunction

endpackage

// File: rtl/pcr_datapath.sv
module pcr_datapath
  import pcr_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pulseIn,
  input  ctrlStrobes_t strobes,
  output logic [7:0]   charOut
);

  logic [2:0]         syncPipe;   // [0],[1] synchroniser, [2] previous sample
  logic               riseSeen;
  logic [COUNT_W-1:0] liveCount;
  logic [COUNT_W-1:0] snapReg;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[1:0], pulseIn};
  end

  assign riseSeen = syncPipe[1] & ~syncPipe[2];

  always_ff @(posedge clk) begin
    if (!rstN)                 liveCount <= '0;
    else if (strobes.clrCount) liveCount <= '0;
    else if (riseSeen)         liveCount <= liveCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 snapReg <= '0;
    else if (strobes.takeSnap) snapReg <= liveCount;
    else if (strobes.shiftNib) snapReg <= {snapReg[COUNT_W-5:0], 4'h0};
  end

  always_comb begin
    case (strobes.charSel)
      SEL_CR:  charOut = CHAR_CR;
      SEL_LF:  charOut = CHAR_LF;
      default: charOut = nibToAscii(snapReg[COUNT_W-1 -: 4]);
    endcase
  end

  a_r3_clear_zeroes : assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCount |=> liveCount == '0);

  a_r2_step_by_one : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clrCount |=> (liveCount == $past(liveCount)) ||
                          (liveCount == $past(liveCount) + 1'b1));

  a_r9_snap_frozen : assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.takeSnap && !strobes.shiftNib) |=> $stable(snapReg));

endmodule

// File: rtl/pcr_control.sv
module pcr_control
  import pcr_pkg::*;
#(
  parameter int NCHARS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   rxByte,
  input  logic         rxValid,
  input  logic         txBusy,
  output logic         txSend,
  output ctrlStrobes_t strobes
);

  localparam int TOTAL  = NCHARS + 2;
  localparam int IDX_W  = $clog2(TOTAL);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND, ST_GAP} state_t;

  state_t           state;
  logic [IDX_W-1:0] charIdx;
  logic             isClear, isSnap, lastChar;

  assign isClear  = rxValid && (rxByte == CMD_CLEAR);
  assign isSnap   = rxValid && (rxByte == CMD_SNAP) && (state == ST_IDLE);
  assign lastChar = (charIdx == IDX_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      charIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (isSnap) begin
          state   <= ST_WAIT;
          charIdx <= '0;
        end
        ST_WAIT: if (!txBusy) state <= ST_SEND;
        ST_SEND: state <= ST_GAP;
        ST_GAP: begin
          if (lastChar) state <= ST_IDLE;
          else begin
            state   <= ST_WAIT;
            charIdx <= charIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.clrCount = isClear;
    strobes.takeSnap = isSnap;
    strobes.shiftNib = (state == ST_GAP) && (charIdx < IDX_W'(NCHARS));
    if (charIdx < IDX_W'(NCHARS))       strobes.charSel = SEL_HEX;
    else if (charIdx == IDX_W'(NCHARS)) strobes.charSel = SEL_CR;
    else                                strobes.charSel = SEL_LF;
  end

  assign txSend = (state == ST_SEND);

  a_r7_single_strobe : assert property (@(posedge clk) disable iff (!rstN)
    txSend |=> !txSend);

  a_r8_idle_before_send : assert property (@(posedge clk) disable iff (!rstN)
    txSend |-> $past(state == ST_WAIT && !txBusy));

  a_r10_no_restart : assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobes.takeSnap);

endmodule

// File: rtl/pulse_count_reporter.sv
module pulse_count_reporter
  import pcr_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseIn,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  output logic [7:0] txByte,
  output logic       txSend,
  input  logic       txBusy
);

  localparam int NCHARS = COUNT_W / 4;

  ctrlStrobes_t strobes;

  pcr_control #(.NCHARS(NCHARS)) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .rxByte  (rxByte),
    .rxValid (rxValid),
    .txBusy  (txBusy),
    .txSend  (txSend),
    .strobes (strobes)
  );

  pcr_datapath #(.COUNT_W(COUNT_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .pulseIn (pulseIn),
    .strobes (strobes),
    .charOut (txByte)
  );

  a_r1_quiet_after_reset : assert property (@(posedge clk)
    !rstN |=> !txSend);

endmodule

// File: tb/pulse_count_reporter_bench.sv
module pulse_count_reporter_bench;

  localparam int CW       = 12;
  localparam int NCH      = CW / 4;
  localparam int RLEN     = NCH + 2;
  localparam int BUSY_LEN = 12;
  localparam int LIMIT    = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       rxValid = 1'b0;
  logic [7:0] txByte;
  logic       txSend;
  logic       txBusy;

  int compared = 0;
  int mismatched = 0;
  int busyCnt = 0;
  int cycles = 0;
  logic prevSend = 1'b0;
  logic [7:0] gotQ[$];
  int unsigned expCount = 0;

  always #2 clk = ~clk;

  assign txBusy = (busyCnt != 0);

  pulse_count_reporter #(.COUNT_W(CW)) u_pulse_count_reporter (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .rxByte(rxByte),
    .rxValid(rxValid), .txByte(txByte), .txSend(txSend), .txBusy(txBusy)
  );

  task automatic printSummary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // transmitter model, sampled away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <=%0d", cycles, LIMIT);
      printSummary();
      $finish;
    end
    if (busyCnt > 0) busyCnt--;
    if (rstN && txSend) begin
      compared++;
      if (prevSend) begin
        mismatched++;
        $display("FAIL R7: txSend high two cycles, actual 1 expected 0");
      end
      compared++;
      if (busyCnt != 0) begin
        mismatched++;
        $display("FAIL R8: byte offered while busy, actual busyCnt=%0d expected 0", busyCnt);
      end
      gotQ.push_back(txByte);
      busyCnt = BUSY_LEN;
    end
    prevSend = txSend;
  end

  function automatic logic [7:0] expChar(input int unsigned v, input int idx);
    logic [3:0] nib;
    if (idx == NCH)     return 8'h0D;
    if (idx == NCH + 1) return 8'h0A;
    nib = 4'((v >> (4 * (NCH - 1 - idx))) & 15);
    return (nib < 10) ? 8'h30 + 8'(nib) : 8'h41 + 8'(nib - 10);
  endfunction

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk);
    rxByte  = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulseIn = 1'b1;
      repeat (2) @(negedge clk);
      pulseIn = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    expCount = (expCount + n) % (1 << CW);
  endtask

  task automatic waitReport(input int startSz, input int unsigned snap, input string tag);
    int guard = 0;
    while (gotQ.size() < startSz + RLEN && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (60) @(negedge clk);
    compared++;
    if (gotQ.size() != startSz + RLEN) begin
      mismatched++;
      $display("FAIL %s: report length actual %0d expected %0d", tag, gotQ.size() - startSz, RLEN);
    end else begin
      for (int i = 0; i < RLEN; i++) begin
        compared++;
        if (gotQ[startSz + i] !== expChar(snap, i)) begin
          mismatched++;
          $display("FAIL %s: char %0d actual %02h expected %02h", tag, i,
                   gotQ[startSz + i], expChar(snap, i));
        end
      end
    end
  endtask

  task automatic report(input string tag);
    int startSz = gotQ.size();
    sendCmd(8'h62);
    waitReport(startSz, expCount, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    compared++;
    if (txSend !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: txSend after reset actual %b expected 0", txSend);
    end
    repeat (30) @(negedge clk);
    compared++;
    if (gotQ.size() != 0) begin
      mismatched++;
      $display("FAIL R1: spontaneous bytes actual %0d expected 0", gotQ.size());
    end
    report("R1 R4 R5 zero report");

    pulses(10);
    report("R2 R6 digit-letter boundary");

    for (int k = 0; k < 6; k++) begin
      pulses($urandom_range(1, 300));
      report("R2 R5 random accumulate");
    end

    sendCmd(8'h61);
    expCount = 0;
    repeat (4) @(negedge clk);
    report("R3 clear");

    sendCmd(8'h61);
    expCount = 0;
    pulses(12'hABC);
    report("R6 letters ABC");

    // R11: junk commands leave output and count alone
    for (int k = 0; k < 4; k++) begin
      logic [7:0] junk;
      int sz;
      junk = 8'($urandom_range(0, 255));
      if (junk == 8'h61 || junk == 8'h62) junk = 8'h63;
      sz = gotQ.size();
      sendCmd(junk);
      repeat (40) @(negedge clk);
      compared++;
      if (gotQ.size() != sz) begin
        mismatched++;
        $display("FAIL R11: junk %02h produced bytes actual %0d expected 0", junk, gotQ.size() - sz);
      end
    end
    report("R11 count untouched by junk");

    // R9 / R10: activity during a report
    begin
      int sz;
      int unsigned snap;
      sendCmd(8'h61);
      expCount = 0;
      pulses(7);
      snap = expCount;
      sz = gotQ.size();
      sendCmd(8'h62);
      pulses(3);
      sendCmd(8'h61);
      expCount = 0;
      pulses(2);
      sendCmd(8'h62);
      waitReport(sz, snap, "R9 R10 snapshot kept, extra request dropped");
      report("R9 live count after mid-report clear");
    end

    sendCmd(8'h61);
    expCount = 0;
    pulses((1 << CW) + 5);
    report("R12 wrap");

    printSummary();
    $finish;
  end

endmodule